// File: doc/BRIEF.md
# Packed Lane Shifter with Rounding and Saturation

This block shifts every lane of a 32-bit packed word by one common amount. It runs in one of two lane layouts: four 8-bit lanes or two 16-bit lanes. The index of the source register picks the lane layout, and it also picks whether the lanes count as signed or unsigned. So the same opcode works on bytes or halfwords, and the register bank decides which.

Three operations are supported: arithmetic right shift, logical right shift and logical left shift. The shift amount comes from a register value or from a 4-bit immediate. Bit 0 of the mode field has a different meaning for each direction:

- On a right shift, it adds the last bit shifted out, which gives round-to-nearest.
- On a left shift, it clamps each lane to its limit instead of letting the top bits wrap. A flag reports when any lane was clamped.

The result and the flag are registered and appear one clock after the inputs.

Top module: `packed_lane_shifter`

## Requirements
- R1: The source index selects the lane type. Values 2–7 give signed 8-bit lanes, 8–15 give unsigned 8-bit lanes, 16–23 give signed 16-bit lanes and 24–29 give unsigned 16-bit lanes. Byte lane k occupies bits [8k+7:8k], and halfword lane k occupies bits [16k+15:16k].
- R2: Source index 0, 1, 30 or 31 gives a result of zero with the flag low.
- R3: The op code selects the operation. 00 is arithmetic right shift, 01 is logical right shift, 10 is logical left shift, and 11 gives a zero result with the flag low. The shift direction comes from the op code only, not from the signedness of the bank.
- R4: With imm_sel high, the amount is the 4-bit immediate; otherwise it is the register amount. Byte lanes use the low 3 bits of the amount and halfword lanes use the low 4 bits. Every lane shifts by the same amount.
- R5: With mode bit 0 low, shifts are plain. A plain left shift drops the bits that leave the lane, and the flag stays low.
- R6: A right shift with mode bit 0 high adds the original lane bit at position (amount−1) to the shifted lane. An amount of 0 leaves every lane unchanged.
- R7: A left shift with mode bit 0 high on a signed bank clamps a lane that would overflow to 0x7F/0x80 (bytes) or to 0x7FFF/0x8000 (halfwords). The sign of the original lane decides which limit is used.
- R8: A left shift with mode bit 0 high on an unsigned bank clamps a lane that would overflow to 0xFF or 0xFFFF.
- R9: The flag is high exactly when at least one lane was clamped. It is never high for a right shift.
- R10: The result and the flag change on the rising clock edge after the inputs are applied. While reset is held (active low), both are zero.
- R11: Mode bit 1 has no effect on the result or the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 2 | Operation code |
| mode_i | input | 2 | Mode field; bit 0 turns on rounding or saturation |
| src_idx_i | input | 5 | Source register index; selects lane width and signedness |
| operand_i | input | 32 | Packed value to shift |
| amt_reg_i | input | 32 | Shift amount from a register |
| imm_sel_i | input | 1 | Selects the immediate amount |
| imm_i | input | 4 | Immediate shift amount |
| result_o | output | 32 | Registered packed result |
| sat_o | output | 1 | Registered flag: some lane was clamped |

## Verification
Some properties hold on every cycle, and the assertions check those:
- An unused register index or the reserved op code gives zero.
- The flag never rises for a right shift or when mode bit 0 is low.
- An amount of zero passes the operand through.
- A plain logical right shift clears the top bit of every lane.

The exact arithmetic can only be shown by the bench's directed scenarios. This covers:
- which bank maps to which lane width,
- rounding values on negative lanes,
- the exact clamp limits at the signed and unsigned edges,
- masking of the register amount to 3 or 4 bits,
- the fact that mode bit 1 is ignored.

// File: rtl/packed_lane_shifter.sv
module packed_lane_shifter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  op_i,
  input  logic [1:0]  mode_i,
  input  logic [4:0]  src_idx_i,
  input  logic [31:0] operand_i,
  input  logic [31:0] amt_reg_i,
  input  logic        imm_sel_i,
  input  logic [3:0]  imm_i,
  output logic [31:0] result_o,
  output logic        sat_o
);
  localparam logic [1:0] OP_SRA = 2'd0;
  localparam logic [1:0] OP_SRL = 2'd1;
  localparam logic [1:0] OP_SLL = 2'd2;

  function automatic logic [16:0] lane_op(input logic [15:0] x, input logic [3:0] s,
                                          input logic w16, input logic [1:0] op,
                                          input logic md, input logic sg);
    logic signed [31:0] e, r, hi, lo;
    logic [31:0] t;
    logic ext_s, sat;
    ext_s = (op == OP_SRA) || (op == OP_SLL && sg);
    if (w16) e = ext_s ? {{16{x[15]}}, x} : {16'b0, x};
    else     e = ext_s ? {{24{x[7]}}, x[7:0]} : {24'b0, x[7:0]};
    r = '0;
    sat = 1'b0;
    t = '0;
    hi = '0;
    lo = '0;
    case (op)
      OP_SRA, OP_SRL: begin
        r = e >>> s;
        if (md && s != 4'd0) begin
          t = e >> (s - 4'd1);
          r = r + {31'b0, t[0]};
        end
      end
      OP_SLL: begin
        r = e <<< s;
        if (md) begin
          hi = sg ? (w16 ? 32'sd32767 : 32'sd127) : (w16 ? 32'sd65535 : 32'sd255);
          lo = sg ? (w16 ? -32'sd32768 : -32'sd128) : 32'sd0;
          if (r > hi) begin r = hi; sat = 1'b1; end
          else if (r < lo) begin r = lo; sat = 1'b1; end
        end
      end
      default: r = '0;
    endcase
    return {sat, r[15:0]};
  endfunction

  function automatic logic [8:0] pick8(input logic [16:0] f);
    return {f[16], f[7:0]};
  endfunction

  logic       bank_ok, is8, sgn;
  logic [3:0] amt;
  logic [31:0] res8, res16, res_d;
  logic [3:0] sat8;
  logic [1:0] sat16;
  logic       sat_d;

  assign bank_ok = (src_idx_i >= 5'd2) && (src_idx_i <= 5'd29);
  assign is8     = src_idx_i < 5'd16;
  assign sgn     = is8 ? (src_idx_i < 5'd8) : (src_idx_i < 5'd24);
  assign amt     = imm_sel_i ? imm_i : amt_reg_i[3:0];

  for (genvar g = 0; g < 4; g++) begin : g_byte
    assign {sat8[g], res8[g*8 +: 8]} =
      pick8(lane_op({8'b0, operand_i[g*8 +: 8]}, {1'b0, amt[2:0]}, 1'b0, op_i, mode_i[0], sgn));
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign {sat16[h], res16[h*16 +: 16]} =
      lane_op(operand_i[h*16 +: 16], amt, 1'b1, op_i, mode_i[0], sgn);
  end

  assign res_d = !bank_ok ? 32'b0 : (is8 ? res8 : res16);
  assign sat_d = bank_ok && (is8 ? |sat8 : |sat16);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_o <= '0;
      sat_o    <= 1'b0;
    end else begin
      result_o <= res_d;
      sat_o    <= sat_d;
    end
  end

  p_bad_bank_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_ok |=> (result_o == 32'b0 && !sat_o));

  p_reserved_op_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 2'd3) |=> (result_o == 32'b0 && !sat_o));

  p_no_flag_plain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_i[0] |=> !sat_o);

  p_no_flag_right_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i != OP_SLL) |=> !sat_o);

  p_zero_amt_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_ok && op_i != 2'd3 && (is8 ? amt[2:0] == 3'd0 : amt == 4'd0))
      |=> (result_o == $past(operand_i) && !sat_o));

  p_srl_top_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_ok && op_i == OP_SRL && !mode_i[0] && (is8 ? amt[2:0] != 3'd0 : amt != 4'd0))
      |=> ($past(is8) ? {result_o[31], result_o[23], result_o[15], result_o[7]} == 4'b0
                      : {result_o[31], result_o[15]} == 2'b0));
endmodule

// File: tb/packed_lane_shifter_test.sv
module packed_lane_shifter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  op_i = '0;
  logic [1:0]  mode_i = '0;
  logic [4:0]  src_idx_i = '0;
  logic [31:0] operand_i = '0;
  logic [31:0] amt_reg_i = '0;
  logic        imm_sel_i = 1'b0;
  logic [3:0]  imm_i = '0;
  logic [31:0] result_o;
  logic        sat_o;
  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  packed_lane_shifter uut (.clk(clk), .rst_n(rst_n), .op_i(op_i), .mode_i(mode_i),
    .src_idx_i(src_idx_i), .operand_i(operand_i), .amt_reg_i(amt_reg_i),
    .imm_sel_i(imm_sel_i), .imm_i(imm_i), .result_o(result_o), .sat_o(sat_o));

  task automatic check(input string tag, input logic [31:0] exp_r, input logic exp_s);
    n_run++;
    if (result_o !== exp_r || sat_o !== exp_s) begin
      n_fail++;
      $display("FAIL %s: result=%h sat=%b expected result=%h sat=%b", tag, result_o, sat_o, exp_r, exp_s);
    end
  endtask

  task automatic run(input logic [1:0] op, input logic [1:0] md, input logic [4:0] idx,
                     input logic [31:0] x, input logic [31:0] amt, input logic isel,
                     input logic [3:0] imm, input string tag,
                     input logic [31:0] exp_r, input logic exp_s);
    @(negedge clk);
    op_i = op; mode_i = md; src_idx_i = idx; operand_i = x;
    amt_reg_i = amt; imm_sel_i = isel; imm_i = imm;
    @(posedge clk);
    #1;
    check(tag, exp_r, exp_s);
  endtask

  task automatic t_reset;
    check("R10 reset", 32'h0, 1'b0);
  endtask

  task automatic t_plain;
    run(2'd0, 2'd0, 5'd3,  32'h8040F007, 32'd2, 1'b0, 4'd0, "R1 R3 sra s8", 32'hE010FC01, 1'b0);
    run(2'd0, 2'd0, 5'd9,  32'h8040F007, 32'd2, 1'b0, 4'd0, "R3 sra on u8 bank", 32'hE010FC01, 1'b0);
    run(2'd1, 2'd0, 5'd20, 32'h8000F00F, 32'd4, 1'b0, 4'd0, "R1 R3 srl s16", 32'h08000F00, 1'b0);
    run(2'd2, 2'd0, 5'd10, 32'h8101FF10, 32'd1, 1'b0, 4'd0, "R5 sll plain wrap", 32'h0202FE20, 1'b0);
  endtask

  task automatic t_amount;
    run(2'd1, 2'd0, 5'd12, 32'hFFFFFFFF, 32'h0000000B, 1'b0, 4'd0, "R4 mask 3 bits", 32'h1F1F1F1F, 1'b0);
    run(2'd1, 2'd0, 5'd25, 32'hFFFFFFFF, 32'h0000000B, 1'b0, 4'd0, "R4 mask 4 bits", 32'h001F001F, 1'b0);
    run(2'd1, 2'd0, 5'd20, 32'h12345678, 32'd1, 1'b1, 4'd4, "R4 immediate", 32'h01230567, 1'b0);
  endtask

  task automatic t_round;
    run(2'd0, 2'd1, 5'd4,  32'h06FB0780, 32'd2, 1'b0, 4'd0, "R6 round sra s8", 32'h02FF02E0, 1'b0);
    run(2'd1, 2'd1, 5'd26, 32'hFFFF0003, 32'd1, 1'b0, 4'd0, "R6 round srl u16", 32'h80000002, 1'b0);
    run(2'd0, 2'd1, 5'd18, 32'hABCD1234, 32'd0, 1'b0, 4'd0, "R6 round amount 0", 32'hABCD1234, 1'b0);
  endtask

  task automatic t_sat;
    run(2'd2, 2'd1, 5'd5,  32'h20E0DF10, 32'd2, 1'b0, 4'd0, "R7 R9 sat s8", 32'h7F808040, 1'b1);
    run(2'd2, 2'd1, 5'd17, 32'h4000C000, 32'd1, 1'b0, 4'd0, "R7 sat s16", 32'h7FFF8000, 1'b1);
    run(2'd2, 2'd1, 5'd14, 32'h807F01FF, 32'd1, 1'b0, 4'd0, "R8 sat u8", 32'hFFFE02FF, 1'b1);
    run(2'd2, 2'd1, 5'd28, 32'h10000FFF, 32'd4, 1'b0, 4'd0, "R8 sat u16", 32'hFFFFFFF0, 1'b1);
    run(2'd2, 2'd1, 5'd5,  32'h10101010, 32'd1, 1'b0, 4'd0, "R9 no clamp", 32'h20202020, 1'b0);
  endtask

  task automatic t_invalid;
    run(2'd1, 2'd0, 5'd0,  32'hFFFFFFFF, 32'd1, 1'b0, 4'd0, "R2 index 0", 32'h0, 1'b0);
    run(2'd1, 2'd0, 5'd1,  32'hFFFFFFFF, 32'd1, 1'b0, 4'd0, "R2 index 1", 32'h0, 1'b0);
    run(2'd2, 2'd1, 5'd31, 32'h7FFFFFFF, 32'd3, 1'b0, 4'd0, "R2 index 31", 32'h0, 1'b0);
    run(2'd3, 2'd1, 5'd5,  32'h12345678, 32'd1, 1'b0, 4'd0, "R3 reserved op", 32'h0, 1'b0);
  endtask

  task automatic t_mode_hi;
    run(2'd0, 2'd3, 5'd4,  32'h06FB0780, 32'd2, 1'b0, 4'd0, "R11 mode 11", 32'h02FF02E0, 1'b0);
    run(2'd2, 2'd2, 5'd5,  32'h20E0DF10, 32'd2, 1'b0, 4'd0, "R11 mode 10", 32'h80807C40, 1'b0);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: result=%h sat=%b expected result=done sat=done", result_o, sat_o);
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_plain();
    t_amount();
    t_round();
    t_sat();
    t_invalid();
    t_mode_hi();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule